// File: doc/BRIEF.md
# Register Write CRC Checker

This block sits behind a configuration packet parser and watches each register write that the parser produces. It receives a one-cycle write strobe together with the register address and the 32-bit data. Every ordinary write is folded into a running 32-bit CRC that covers both the address and the data. The stream confirms its integrity by writing the value it expects into a dedicated check register. That write is compared with the running value, and any difference raises a sticky error flag.

A write to the command register carrying the CRC-reset code clears the running value. A stream can therefore swap its check writes for resets and never be checked. A stream that never writes the check register can never raise the error. Each update takes a single cycle, so a write can arrive on every clock.

Top module: `crc_check`

## Requirements
- R1: After the active-low reset `rst_n` is released, `crc_now` reads 0 and `crc_err` reads 0.
- R2: An ordinary write (strobe high, and neither a check write nor a reset command) folds 37 bits into the running value, and the result shows on `crc_now` one clock later. The 37 bits are the 5-bit address followed by the 32-bit data, each taken LSB first. Each bit b updates the state c as follows: feedback = c[31] XOR b, c = c shifted left by one, and when the feedback is 1, c is XORed with 0x1EDC6F41.
- R3: When `wr_stb` is low, `crc_now` and `crc_err` keep their values, whatever is on the address and data inputs.
- R4: A write to address 0 (the check register) is compared with the running value and is never folded into it.
- R5: A check write whose data equals the running value sets the running value to 0 on the next clock and leaves `crc_err` unchanged.
- R6: A check write whose data differs from the running value sets `crc_err` to 1 on the next clock and leaves the running value unchanged.
- R7: Once set, `crc_err` stays 1 until reset, including across later matching check writes.
- R8: A write to address 4 (the command register) with data 7 clears the running value to 0 and is not folded. A command-register write with any other data is folded as an ordinary write.
- R9: A stream that contains no write to address 0 never sets `crc_err`.
- R10: Writes on consecutive clocks are each folded, in order, with no cycle lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe for each register write |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 32 | Data word of the write |
| crc_now | output | 32 | Running CRC value |
| crc_err | output | 1 | Sticky CRC mismatch flag |

## Verification
The bench checks that the check write and the reset command are excluded from the running value. A design that folded either of them would show a wrong `crc_now` on the following ordinary write. A matching check write must be followed by a zero running value, and a later matching check must not clear the error. A design that got these wrong would either carry a stale CRC forward or lose an earlier mismatch. Non-reset command data is folded like any other write, which catches a decoder that looks only at the address. A long burst of writes with no check write guards against an error flag that is raised on a compare nobody asked for.

// File: rtl/crc_check_pkg.sv
// Shared definitions for the register write CRC checker.
// Assumes: one register write at most per clock.
package crc_check_pkg;

    // Class of a single register write, as seen by the checker
    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,   // no write this cycle
        WK_FOLD  = 2'd1,   // ordinary write, folded into the CRC
        WK_CHECK = 2'd2,   // expected value written to the check register
        WK_CLEAR = 2'd3    // reset-CRC command
    } wr_kind_t;

    localparam logic [31:0] CRC_POLY = 32'h1EDC6F41;

endpackage

// File: rtl/crc_fold.sv
// Combinational parallel CRC step: folds IN_W message bits, LSB first,
// into a CRC_W-bit state. The result equals IN_W iterations of the
// shift-left serial form with polynomial POLY.
// Assumes: msg[0] is the first bit on the serial line.
module crc_fold #(
    parameter int          CRC_W = 32,
    parameter int          IN_W  = 37,
    parameter logic [CRC_W-1:0] POLY = crc_check_pkg::CRC_POLY
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [IN_W-1:0]  msg,
    output logic [CRC_W-1:0] crc_out
);

    // Unrolled serial recurrence, one stage per message bit
    always_comb begin
        logic [CRC_W-1:0] st;
        logic             fb;
        st = crc_in;
        for (int i = 0; i < IN_W; i++) begin
            fb = st[CRC_W-1] ^ msg[i];
            st = {st[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_out = st;
    end

endmodule

// File: rtl/crc_wr_classify.sv
// Sorts each incoming register write into idle, fold, check or clear.
// Assumes: the check and command registers have distinct addresses.
module crc_wr_classify
    import crc_check_pkg::*;
#(
    parameter int                ADDR_W   = 5,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CHK_ADDR = '0,
    parameter logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(4),
    parameter logic [DATA_W-1:0] CLR_CODE = DATA_W'(7)
) (
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output wr_kind_t          kind
);

    // Decode the write class from the address and, for commands, the data
    always_comb begin
        if (!stb)
            kind = WK_IDLE;
        else if (addr == CHK_ADDR)
            kind = WK_CHECK;
        else if (addr == CMD_ADDR && data == CLR_CODE)
            kind = WK_CLEAR;
        else
            kind = WK_FOLD;
    end

endmodule

// File: rtl/crc_check.sv
// Register write CRC checker. Folds every ordinary register write
// (address then data) into a running CRC. It compares writes to the check
// register against that value and latches a sticky error on a mismatch.
// A reset-CRC command clears the running value.
// Assumes: writes arrive as single-cycle strobes; reset is synchronous.
module crc_check
    import crc_check_pkg::*;
#(
    parameter int                ADDR_W   = 5,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CHK_ADDR = '0,
    parameter logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(4),
    parameter logic [DATA_W-1:0] CLR_CODE = DATA_W'(7)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [31:0]       crc_now,
    output logic              crc_err
);

    localparam int CRC_W = 32;
    localparam int MSG_W = ADDR_W + DATA_W;

    wr_kind_t         kind;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_folded;
    logic             err_q;
    logic             match;

    crc_wr_classify #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CHK_ADDR(CHK_ADDR),
        .CMD_ADDR(CMD_ADDR),
        .CLR_CODE(CLR_CODE)
    ) u_classify (
        .stb (wr_stb),
        .addr(wr_addr),
        .data(wr_data),
        .kind(kind)
    );

    crc_fold #(
        .CRC_W(CRC_W),
        .IN_W (MSG_W),
        .POLY (CRC_POLY)
    ) u_fold (
        .crc_in (crc_q),
        .msg    ({wr_data, wr_addr}),
        .crc_out(crc_folded)
    );

    // Compare the expected value against the running CRC
    always_comb match = (CRC_W'(wr_data) == crc_q);

    // Running CRC register: fold, clear, or zero after a good check
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= '0;
        else begin
            case (kind)
                WK_FOLD:  crc_q <= crc_folded;
                WK_CLEAR: crc_q <= '0;
                WK_CHECK: if (match) crc_q <= '0;
                default:  crc_q <= crc_q;
            endcase
        end
    end

    // Sticky mismatch flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (kind == WK_CHECK && !match)
            err_q <= 1'b1;
    end

    assign crc_now = crc_q;
    assign crc_err = err_q;

endmodule

// File: rtl/crc_check_props.sv
// Property checker for crc_check, attached by bind below.
// Assumes: the same parameter values as the bound instance.
module crc_check_props #(
    parameter int                ADDR_W   = 5,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CHK_ADDR = '0,
    parameter logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(4),
    parameter logic [DATA_W-1:0] CLR_CODE = DATA_W'(7)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [31:0]       crc_now,
    input logic              crc_err
);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(crc_now) && $stable(crc_err)));

    assert_match_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == CHK_ADDR && 32'(wr_data) == crc_now)
        |=> (crc_now == 32'd0 && $stable(crc_err)));

    assert_mismatch_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == CHK_ADDR && 32'(wr_data) != crc_now)
        |=> (crc_err && $stable(crc_now)));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> crc_err);

    assert_clear_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == CMD_ADDR && wr_data == CLR_CODE)
        |=> (crc_now == 32'd0));

    assert_err_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> $past(wr_stb && wr_addr == CHK_ADDR));

endmodule

bind crc_check crc_check_props #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CHK_ADDR(CHK_ADDR),
    .CMD_ADDR(CMD_ADDR),
    .CLR_CODE(CLR_CODE)
) u_props (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .crc_now(crc_now),
    .crc_err(crc_err)
);

// File: tb/sim_crc_check.sv
// Self-checking bench for crc_check: a vector table walked by one loop,
// then directed reset and long no-check stream tests.
module sim_crc_check;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    // Vector layout: {kind[1:0], stb, addr[4:0], data[31:0]}
    // kind 0 = literal data, 1 = data replaced by the correct CRC,
    // kind 2 = data replaced by a wrong CRC
    localparam logic [39:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 5'd2,  32'h0000_0000},   // R2 zero word
        {2'd0, 1'b1, 5'd1,  32'hDEAD_BEEF},   // R2
        {2'd0, 1'b0, 5'd0,  32'h1234_5678},   // R3 idle with junk inputs
        {2'd0, 1'b1, 5'd9,  32'h0000_0001},   // R10
        {2'd1, 1'b1, 5'd0,  32'h0},           // R5 good check
        {2'd0, 1'b1, 5'd3,  32'h0000_A5A5},   // R2 / R4 (check not folded)
        {2'd0, 1'b1, 5'd4,  32'h0000_0007},   // R8 clear command
        {2'd0, 1'b1, 5'd17, 32'hFFFF_FFFF},   // R2
        {2'd0, 1'b1, 5'd4,  32'h0000_0003},   // R8 other command folded
        {2'd2, 1'b1, 5'd0,  32'h0},           // R6 bad check
        {2'd0, 1'b1, 5'd31, 32'h0000_0001},   // R2
        {2'd1, 1'b1, 5'd0,  32'h0},           // R7 good check, err stays
        {2'd0, 1'b0, 5'd4,  32'h0000_0007},   // R3 idle with clear code
        {2'd0, 1'b1, 5'd4,  32'h0000_0007}    // R8
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_stb;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic [31:0] crc_now;
    logic        crc_err;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_crc;
    logic        m_err;

    crc_check u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .crc_now(crc_now),
        .crc_err(crc_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference CRC step, written from requirement R2
    function automatic logic [31:0] ref_fold(input logic [31:0] c,
                                             input logic [4:0]  a,
                                             input logic [31:0] d);
        logic [36:0] m;
        logic        fb;
        m = {d, a};
        for (int i = 0; i < 37; i++) begin
            fb = c[31] ^ m[i];
            c  = {c[30:0], 1'b0} ^ (fb ? 32'h1EDC6F41 : 32'h0);
        end
        return c;
    endfunction

    task automatic check_val(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Update the reference model for one write, from the requirements
    task automatic model_step(input logic s, input logic [4:0] a, input logic [31:0] d);
        if (!s) return;
        if (a == 5'd0) begin
            if (d == m_crc) m_crc = 32'h0;
            else            m_err = 1'b1;
        end else if (a == 5'd4 && d == 32'd7)
            m_crc = 32'h0;
        else
            m_crc = ref_fold(m_crc, a, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        wr_stb  = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_crc = 32'h0;
        m_err = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        check_val("R1", "crc_now after reset", crc_now, 32'h0);
        check_val("R1", "crc_err after reset", {31'b0, crc_err}, 32'h0);

        // Table walk: inputs held one cycle each, back to back
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]  k;
            logic        s;
            logic [4:0]  a;
            logic [31:0] d;
            string       tag;
            k = VEC[v][39:38];
            s = VEC[v][37];
            a = VEC[v][36:32];
            d = VEC[v][31:0];
            if (k == 2'd1) d = m_crc;
            if (k == 2'd2) d = m_crc ^ 32'h0000_0100;
            if (!s)                          tag = "R3";
            else if (a == 5'd0 && k == 2'd2) tag = "R6";
            else if (a == 5'd0 && m_err)     tag = "R7";
            else if (a == 5'd0)              tag = "R5";
            else if (a == 5'd4)              tag = "R8";
            else                             tag = "R2";
            @(negedge clk);
            wr_stb  = s;
            wr_addr = a;
            wr_data = d;
            model_step(s, a, d);
            @(posedge clk);
            #1;
            check_val(tag, "crc_now", crc_now, m_crc);
            check_val(tag, "crc_err", {31'b0, crc_err}, {31'b0, m_err});
        end
        @(negedge clk);
        wr_stb = 1'b0;

        // R1: reset clears a raised error and a nonzero CRC
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = 5'd6; wr_data = 32'hCAFE_0001;
        @(negedge clk);
        wr_stb = 1'b0;
        do_reset();
        #1;
        check_val("R1", "crc_now after second reset", crc_now, 32'h0);
        check_val("R1", "crc_err after second reset", {31'b0, crc_err}, 32'h0);

        // R9 / R10: long burst without any check write, including commands
        for (int n = 0; n < 40; n++) begin
            logic [4:0]  a;
            logic [31:0] d;
            a = 5'(n % 31 + 1);
            d = 32'h9E37_79B9 * (n + 3);
            if (n % 13 == 5) begin a = 5'd4; d = 32'd7; end
            @(negedge clk);
            wr_stb = 1'b1; wr_addr = a; wr_data = d;
            model_step(1'b1, a, d);
        end
        @(negedge clk);
        wr_stb = 1'b0;
        #1;
        check_val("R10", "crc_now after burst", crc_now, m_crc);
        check_val("R9", "crc_err after burst", {31'b0, crc_err}, 32'h0);

        // R4 / R5: a correct check, then a fold starting from zero
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = 5'd0; wr_data = m_crc;
        model_step(1'b1, 5'd0, wr_data);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = 5'd12; wr_data = 32'h0BAD_F00D;
        model_step(1'b1, 5'd12, wr_data);
        @(negedge clk);
        wr_stb = 1'b0;
        check_val("R4", "crc_now after check then fold", crc_now,
                  ref_fold(32'h0, 5'd12, 32'h0BAD_F00D));
        check_val("R5", "crc_err after correct check", {31'b0, crc_err}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule